// File: doc/BRIEF.md
# Serial Pad Configuration Cell

This cell holds the 13-bit control word of one pad and sits in a daisy chain. A serial loader writes every word in the chain. The cell sees three serial lines: a serial clock, an active-low strobe line, and a data input. It shifts data through a 13-bit shift register. It forwards the top bit of that register to the next cell in the chain. A separate active register feeds the pad controls.

The loader sends the word for the farthest cell first, most significant bit first. The loader changes data only while the serial clock is low, and the cell captures one bit on each rising edge. To finish a transfer, the loader pulls the strobe low while the serial clock is high, and every cell then copies its shift register into its active register. If the strobe is low while the serial clock is low, the cell clears its shift register and restores its default word instead. The default word depends on a parameter: 0x1803 for a bidirectional pad or 0x0403 for an input-only pad.

The cell samples the three serial lines with a local clock. This clock must be the loader's clock or a faster synchronous clock. The cell detects edges of the serial lines by comparing each sample with the one before it.

Top module: `padcfg_cell`

## Requirements
- R1: While `rst_n` is low, the active word `cfg` equals the default and the shift register is cleared. The default is 0x1803 when `BIDIR` is 1 and 0x0403 when `BIDIR` is 0.
- R2: A rising edge of the serial clock is a `clk` cycle where `sclk` samples 1 and sampled 0 on the cycle before. On such a cycle, if `sload_n` is high, the cell shifts the register left by one and puts `sdi` into bit 0. Words therefore enter most significant bit first.
- R3: `sdo` always equals bit 12 of the shift register. In a chain of N cells, after 13·N shifts the cell nearest the loader holds the last word sent.
- R4: A load happens when `sload_n` samples 0, sampled 1 on the cycle before, and `sclk` samples 1. The shift register is then copied into `cfg`, and the new value is visible after that `clk` edge.
- R5: When `sload_n` and `sclk` both sample 0, the shift register is cleared and `cfg` returns to its default. A load pulse that follows with no shifting therefore yields `cfg` = 0.
- R6: `cfg` does not change in any cycle where `sload_n` samples 1, including during shifting.
- R7: `oe_n` equals bit 1 of `cfg` (active-low output enable). `in_dis` equals bit 3 of `cfg` (input disable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Power-up reset, active low |
| sclk | input | 1 | Serial clock from the loader |
| sload_n | input | 1 | Strobe line: load when serial clock is high, default when low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out to the next cell |
| cfg | output | 13 | Active configuration word |
| oe_n | output | 1 | Output enable, active low |
| in_dis | output | 1 | Input disable |

## Verification
The assertions assume that every serial line level lasts at least one `clk` cycle, so the sampled edges line up with the loader's edges. They also assume that `sdi` changes only while `sclk` is low. The stimulus holds every level for two `clk` cycles and changes data only in the low phase of the serial clock. It ends each transfer with the sequence clock high, strobe low, strobe high, clock low. Random words and directed default pulses are sent through a chain of three cells with mixed `BIDIR` settings.

// File: rtl/padcfg_cell.sv
module padcfg_cell #(
  parameter int WIDTH = 13,
  parameter bit BIDIR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sload_n,
  input  logic             sdi,
  output logic             sdo,
  output logic [WIDTH-1:0] cfg,
  output logic             oe_n,
  output logic             in_dis
);
  localparam logic [WIDTH-1:0] DEFAULT = BIDIR ? WIDTH'(13'h1803) : WIDTH'(13'h0403);
  localparam int OE_BIT  = 1;
  localparam int DIS_BIT = 3;

  logic [WIDTH-1:0] sh;
  logic sclk_q, sload_q;

  wire rise    = sclk && !sclk_q;
  wire do_load = sload_q && !sload_n && sclk;
  wire do_def  = !sload_n && !sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sload_q <= 1'b0;
      sh      <= '0;
      cfg     <= DEFAULT;
    end else begin
      sclk_q  <= sclk;
      sload_q <= sload_n;
      if (do_def) begin
        sh  <= '0;
        cfg <= DEFAULT;
      end else begin
        if (rise && sload_n) sh <= {sh[WIDTH-2:0], sdi};
        if (do_load) cfg <= sh;
      end
    end
  end

  assign sdo    = sh[WIDTH-1];
  assign oe_n   = cfg[OE_BIT];
  assign in_dis = cfg[DIS_BIT];

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !sclk_q && sload_n) |=> (sh[0] == $past(sdi)));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sload_q && !sload_n && sclk) |=> (cfg == $past(sh)));
  assert_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sload_n && !sclk) |=> (cfg == DEFAULT && sdo == 1'b0));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sload_n |=> $stable(cfg));
endmodule

// File: tb/sim_padcfg_cell.sv
module sim_padcfg_cell;
  localparam int PERIOD = 10;
  localparam int W = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sload_n = 1'b0, sdi = 1'b0;
  logic s01, s12, sdo;
  logic [W-1:0] c0, c1, c2;
  logic oe0, oe1, oe2, id0, id1, id2;
  int checks = 0, errors = 0;
  logic [W-1:0] w [3];
  logic [W-1:0] held [3];

  always #(PERIOD/2) clk = ~clk;

  padcfg_cell #(.WIDTH(W), .BIDIR(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sload_n(sload_n),
    .sdi(sdi), .sdo(s01), .cfg(c0), .oe_n(oe0), .in_dis(id0));
  padcfg_cell #(.WIDTH(W), .BIDIR(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sload_n(sload_n),
    .sdi(s01), .sdo(s12), .cfg(c1), .oe_n(oe1), .in_dis(id1));
  padcfg_cell #(.WIDTH(W), .BIDIR(1'b1)) u2 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sload_n(sload_n),
    .sdi(s12), .sdo(sdo), .cfg(c2), .oe_n(oe2), .in_dis(id2));

  function automatic logic [W-1:0] dflt(input bit bidir);
    return bidir ? 13'h1803 : 13'h0403;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic d);
    @(negedge clk);
    sclk = c; sload_n = l; sdi = d;
    @(negedge clk);
  endtask

  task automatic check_cells(input string req, input logic [W-1:0] e0, input logic [W-1:0] e1,
                             input logic [W-1:0] e2);
    chk(req, c0, e0); chk(req, c1, e1); chk(req, c2, e2);
    chk({req, "_R7_oe"}, W'({oe0, oe1, oe2}), W'({e0[1], e1[1], e2[1]}));
    chk({req, "_R7_dis"}, W'({id0, id1, id2}), W'({e0[3], e1[3], e2[3]}));
  endtask

  task automatic load_pulse();
    drive(1'b1, 1'b1, sdi);
    drive(1'b1, 1'b0, sdi);
    drive(1'b1, 1'b1, sdi);
    drive(1'b0, 1'b1, sdi);
  endtask

  task automatic send_all(input bit check_hold);
    for (int k = 2; k >= 0; k--) begin
      for (int b = W - 1; b >= 0; b--) begin
        drive(1'b0, 1'b1, w[k][b]);
        drive(1'b1, 1'b1, w[k][b]);
        if (check_hold && b == 6) check_cells("R6_hold_during_shift", held[0], held[1], held[2]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_cells("R1_reset", dflt(1), dflt(0), dflt(1));
    chk("R1_sdo_reset", W'(sdo), '0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 1'b1, 1'b0);
    check_cells("R1_after_release", dflt(1), dflt(0), dflt(1));
    held[0] = dflt(1); held[1] = dflt(0); held[2] = dflt(1);

    w[0] = 13'h1FFF; w[1] = 13'h0000; w[2] = 13'h1555;
    send_all(1'b1);
    chk("R3_sdo_chain_end", W'(sdo), W'(w[2][W-1]));
    load_pulse();
    check_cells("R4_load_directed", w[0], w[1], w[2]);
    held[0] = w[0]; held[1] = w[1]; held[2] = w[2];

    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < 3; k++) w[k] = W'($urandom);
      send_all(1'b1);
      chk("R2_R3_sdo_after_shift", W'(sdo), W'(w[2][W-1]));
      load_pulse();
      check_cells("R4_load_random", w[0], w[1], w[2]);
      held[0] = w[0]; held[1] = w[1]; held[2] = w[2];
    end

    drive(1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b1);
    check_cells("R6_partial_shift", held[0], held[1], held[2]);

    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    check_cells("R5_default", dflt(1), dflt(0), dflt(1));
    chk("R5_sdo_cleared", W'(sdo), '0);
    load_pulse();
    check_cells("R5_cleared_shift", '0, '0, '0);

    w[0] = 13'h0002; w[1] = 13'h0008; w[2] = 13'h000A;
    send_all(1'b0);
    load_pulse();
    check_cells("R7_pin_bits", w[0], w[1], w[2]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule